// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits at the head of an Ethernet receive path and decides, once per frame, whether the frame is kept or dropped. Bytes arrive one per cycle on a valid strobe, with start and end markers. The declared byte length of the frame comes with them and is captured on the start byte. The filter looks only at the first six bytes, which form the destination address. It classifies that address as broadcast, multicast or unicast. It then applies the configured rules and a length limit, and produces a single registered verdict.

Five configuration words are written through a simple write port. Two of them together hold the 48-bit station address. One holds the largest frame length allowed. The last two hold per-class drop bits and per-class don't-care bits, and a set don't-care bit always beats a set drop bit. Every rule reads the configuration as it stands in the cycle the verdict is formed.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset the length limit is 1536 bytes, no drop bit is set and both don't-care bits are set, so broadcast and multicast frames up to 1536 bytes are accepted; `dec_vld` and `dec_accept` are 0 during and right after reset.
- R2: A frame whose declared length is greater than the low 16 bits of the length-limit word is dropped; a length equal to the limit passes the length rule.
- R3: A frame whose declared length is below 6, or whose end marker comes before its sixth byte, is dropped. In the second case the verdict follows the end byte by one cycle and carries class 2'b11.
- R4: A destination of six 0xFF bytes is broadcast, with class 2'b10. It is accepted when bit 9 of the don't-care word is set or bit 9 of the drop word is clear.
- R5: A non-broadcast destination whose first byte has bit 0 set is multicast, with class 2'b01. It is accepted under the same rule as broadcast, using bit 8 of each of the two words.
- R6: For each of broadcast and multicast, a set don't-care bit makes the frame pass the address rule even when the matching drop bit is set.
- R7: Any other destination has class 2'b00 and is accepted only if all six bytes equal the station address. Station word A holds octet 1 in bits [31:24] down to octet 4 in [7:0]. Station word B holds octet 5 in [31:24] and octet 6 in [23:16], and its bits [15:0] have no effect. Octet 1 is the first byte on the wire.
- R8: Exactly one single-cycle `dec_vld` pulse is produced per frame, in the cycle after the sixth byte is taken. Bytes after the sixth have no effect, and a start byte in the middle of a frame restarts the scan.
- R9: `dec_accept` and `dec_class` are valid while `dec_vld` is high.
- R10: Write select codes are 0 for station word A, 1 for station word B, 2 for the length limit (bits [15:0] used), 3 for the drop word and 4 for the don't-care word. Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Configuration word select |
| cfg_wr_data | input | 32 | Configuration write data |
| rx_byte_vld | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_frame_len | input | 16 | Declared frame length in bytes, captured with `rx_sof` |
| dec_vld | output | 1 | Verdict strobe |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| dec_class | output | 2 | 00 unicast, 01 multicast, 10 broadcast, 11 short |

## Verification
Some properties are checked on every cycle. A verdict never appears unless a byte was taken the cycle before. A short frame is never accepted. No accepted frame exceeds the length limit that was in force. A set don't-care bit always lets an in-limit broadcast or multicast frame through. The limit word moves only on a write to its own select code. Only the directed scenarios can show the exact pulse position, the octet ordering of the station address, the ignored low half of station word B, the inert select codes and the mid-frame restart, since each of these needs a known address or length to compare against.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      CLS_UNICAST   = 2'b00,
      CLS_MULTICAST = 2'b01,
      CLS_BROADCAST = 2'b10,
      CLS_RUNT      = 2'b11
   } rxf_class_e;

   localparam logic [2:0] SEL_STA_A  = 3'd0;
   localparam logic [2:0] SEL_STA_B  = 3'd1;
   localparam logic [2:0] SEL_MAXLEN = 3'd2;
   localparam logic [2:0] SEL_DROP   = 3'd3;
   localparam logic [2:0] SEL_DCARE  = 3'd4;

   typedef struct packed {
      logic bc;
      logic mc;
      logic uc_hit;
   } rxf_addr_flags_t;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
   import rxf_pkg::*;
#(
   parameter int          REG_W      = 32,
   parameter int          LEN_W      = 16,
   parameter int          ADDR_BYTES = 6,
   parameter int          SEL_W      = 3,
   parameter logic [31:0] MAXLEN_RST = 32'h0000_0600,
   parameter logic [31:0] DROP_RST   = 32'h0000_0000,
   parameter logic [31:0] DCARE_RST  = 32'h0003_FFFF,
   parameter int          BCAST_BIT  = 9,
   parameter int          MCAST_BIT  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [SEL_W-1:0]          wr_sel,
   input  logic [REG_W-1:0]          wr_data,
   output logic [ADDR_BYTES*8-1:0]   station_o,
   output logic [LEN_W-1:0]          max_len_o,
   output logic                      bc_drop_o,
   output logic                      mc_drop_o,
   output logic                      bc_dcare_o,
   output logic                      mc_dcare_o
);

   localparam int HI_BYTES = REG_W / 8;
   localparam int LO_BYTES = ADDR_BYTES - HI_BYTES;
   localparam int LO_W     = LO_BYTES * 8;

   generate
      if (LO_BYTES < 1 || LO_BYTES > HI_BYTES) begin : g_bad_split
         $error("rxf_cfg_regs: station address does not split over two words");
      end
      if (LEN_W > REG_W) begin : g_bad_len
         $error("rxf_cfg_regs: LEN_W wider than a register");
      end
      if (BCAST_BIT >= REG_W || MCAST_BIT >= REG_W || BCAST_BIT == MCAST_BIT) begin : g_bad_bits
         $error("rxf_cfg_regs: class bit positions invalid");
      end
   endgenerate

   logic [REG_W-1:0] sta_a_q;
   logic [LO_W-1:0]  sta_b_q;
   logic [LEN_W-1:0] maxlen_q;
   logic             bc_drop_q, mc_drop_q, bc_dcare_q, mc_dcare_q;

   wire wr_a   = wr_en && (wr_sel == SEL_W'(SEL_STA_A));
   wire wr_b   = wr_en && (wr_sel == SEL_W'(SEL_STA_B));
   wire wr_max = wr_en && (wr_sel == SEL_W'(SEL_MAXLEN));
   wire wr_dr  = wr_en && (wr_sel == SEL_W'(SEL_DROP));
   wire wr_dc  = wr_en && (wr_sel == SEL_W'(SEL_DCARE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_a_q    <= '0;
         sta_b_q    <= '0;
         maxlen_q   <= MAXLEN_RST[LEN_W-1:0];
         bc_drop_q  <= DROP_RST[BCAST_BIT];
         mc_drop_q  <= DROP_RST[MCAST_BIT];
         bc_dcare_q <= DCARE_RST[BCAST_BIT];
         mc_dcare_q <= DCARE_RST[MCAST_BIT];
      end else begin
         if (wr_a)   sta_a_q  <= wr_data;
         if (wr_b)   sta_b_q  <= wr_data[REG_W-1 -: LO_W];
         if (wr_max) maxlen_q <= wr_data[LEN_W-1:0];
         if (wr_dr) begin
            bc_drop_q <= wr_data[BCAST_BIT];
            mc_drop_q <= wr_data[MCAST_BIT];
         end
         if (wr_dc) begin
            bc_dcare_q <= wr_data[BCAST_BIT];
            mc_dcare_q <= wr_data[MCAST_BIT];
         end
      end
   end

   // octet 1 of the address lands in the top byte of station_o
   assign station_o  = {sta_a_q, sta_b_q};
   assign max_len_o  = maxlen_q;
   assign bc_drop_o  = bc_drop_q;
   assign mc_drop_o  = mc_drop_q;
   assign bc_dcare_o = bc_dcare_q;
   assign mc_dcare_o = mc_dcare_q;

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{MAXLEN_RST, DROP_RST, DCARE_RST, wr_data};

endmodule

// File: rtl/rxf_addr_scan.sv
module rxf_addr_scan
   import rxf_pkg::*;
#(
   parameter int ADDR_BYTES   = 6,
   parameter int DATA_W       = 8,
   parameter int LEN_W        = 16,
   parameter bit PARALLEL_CMP = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         byte_vld,
   input  logic [DATA_W-1:0]            byte_data,
   input  logic                         byte_sof,
   input  logic                         byte_eof,
   input  logic [LEN_W-1:0]             frame_len,
   input  logic [ADDR_BYTES*DATA_W-1:0] station,
   output logic                         evt_o,
   output logic                         runt_o,
   output rxf_addr_flags_t              flags_o,
   output logic [LEN_W-1:0]             len_o
);

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam int IDX_W = $clog2(ADDR_BYTES);
   localparam int AW    = ADDR_BYTES * DATA_W;

   generate
      if (ADDR_BYTES < 2) begin : g_bad_bytes
         $error("rxf_addr_scan: address needs at least two bytes");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("rxf_addr_scan: byte lanes must be 8 bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [LEN_W-1:0] len_q;

   logic [CNT_W-1:0] idx;
   logic             take, at_last, at_first;

   always_comb begin
      idx      = byte_sof ? '0 : cnt_q;
      take     = byte_vld && (byte_sof || busy_q);
      at_first = (idx == '0);
      at_last  = (idx == CNT_W'(ADDR_BYTES - 1));
   end

   assign evt_o  = take && (at_last || byte_eof);
   assign runt_o = !at_last;
   assign len_o  = byte_sof ? frame_len : len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         len_q  <= '0;
      end else if (take) begin
         cnt_q  <= idx + CNT_W'(1);
         busy_q <= !(at_last || byte_eof);
         if (byte_sof) len_q <= frame_len;
      end
   end

   // station octets, octet 0 is the first byte on the wire
   logic [DATA_W-1:0] st_oct [ADDR_BYTES];
   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_oct
      assign st_oct[g] = station[(ADDR_BYTES-1-g)*DATA_W +: DATA_W];
   end

   generate
      if (PARALLEL_CMP) begin : g_parallel
         logic [DATA_W-1:0] da_q [ADDR_BYTES-1];
         logic [AW-1:0]     da_full;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < ADDR_BYTES-1; i++) da_q[i] <= '0;
            end else if (take && !at_last) begin
               da_q[idx[IDX_W-1:0]] <= byte_data;
            end
         end

         for (genvar g = 0; g < ADDR_BYTES-1; g++) begin : g_cat
            assign da_full[(ADDR_BYTES-1-g)*DATA_W +: DATA_W] = da_q[g];
         end
         assign da_full[DATA_W-1:0] = byte_data;

         logic bc_w;
         assign bc_w           = &da_full;
         assign flags_o.bc     = bc_w;
         assign flags_o.mc     = da_full[AW-DATA_W] && !bc_w;
         assign flags_o.uc_hit = (da_full == station);

         logic unused_par;
         assign unused_par = ^{at_first, st_oct[0]};
      end else begin : g_running
         logic bc_q, mc_q, uc_q;
         logic bc_n, mc_n, uc_n;

         always_comb begin
            bc_n = (at_first ? 1'b1 : bc_q) && (byte_data == '1);
            uc_n = (at_first ? 1'b1 : uc_q) && (byte_data == st_oct[idx[IDX_W-1:0]]);
            mc_n = at_first ? byte_data[0] : mc_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bc_q <= 1'b0;
               mc_q <= 1'b0;
               uc_q <= 1'b0;
            end else if (take) begin
               bc_q <= bc_n;
               mc_q <= mc_n;
               uc_q <= uc_n;
            end
         end

         assign flags_o.bc     = bc_n;
         assign flags_o.mc     = mc_n && !bc_n;
         assign flags_o.uc_hit = uc_n;
      end
   endgenerate

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int ADDR_BYTES = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt,
   input  logic            runt,
   input  rxf_addr_flags_t flags,
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W-1:0] max_len,
   input  logic            bc_drop,
   input  logic            mc_drop,
   input  logic            bc_dcare,
   input  logic            mc_dcare,
   output logic            dec_vld_o,
   output logic            dec_accept_o,
   output logic [1:0]      dec_class_o
);

   rxf_class_e cls;
   logic       len_ok, addr_ok, acc;

   always_comb begin
      if (runt)          cls = CLS_RUNT;
      else if (flags.bc) cls = CLS_BROADCAST;
      else if (flags.mc) cls = CLS_MULTICAST;
      else               cls = CLS_UNICAST;

      len_ok = (len <= max_len) && (len >= LEN_W'(ADDR_BYTES));

      unique case (cls)
         CLS_BROADCAST: addr_ok = bc_dcare || !bc_drop;
         CLS_MULTICAST: addr_ok = mc_dcare || !mc_drop;
         CLS_UNICAST:   addr_ok = flags.uc_hit;
         default:       addr_ok = 1'b0;
      endcase

      acc = len_ok && addr_ok;
   end

   logic       vld_q, acc_q;
   rxf_class_e cls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         acc_q <= 1'b0;
         cls_q <= CLS_UNICAST;
      end else begin
         vld_q <= evt;
         acc_q <= evt && acc;
         if (evt) cls_q <= cls;
      end
   end

   assign dec_vld_o    = vld_q;
   assign dec_accept_o = acc_q;
   assign dec_class_o  = cls_q;

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
   import rxf_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter int          ADDR_BYTES   = 6,
   parameter int          LEN_W        = 16,
   parameter int          REG_W        = 32,
   parameter int          SEL_W        = 3,
   parameter logic [31:0] MAXLEN_RST   = 32'h0000_0600,
   parameter logic [31:0] DROP_RST     = 32'h0000_0000,
   parameter logic [31:0] DCARE_RST    = 32'h0003_FFFF,
   parameter int          BCAST_BIT    = 9,
   parameter int          MCAST_BIT    = 8,
   parameter bit          PARALLEL_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [SEL_W-1:0]  cfg_wr_sel,
   input  logic [REG_W-1:0]  cfg_wr_data,
   input  logic              rx_byte_vld,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic [LEN_W-1:0]  rx_frame_len,
   output logic              dec_vld,
   output logic              dec_accept,
   output logic [1:0]        dec_class
);

   localparam int AW = ADDR_BYTES * DATA_W;

   generate
      if (SEL_W < 3) begin : g_bad_sel
         $error("rx_accept_filter: select needs at least three bits");
      end
   endgenerate

   logic [AW-1:0]    station_w;
   logic [LEN_W-1:0] max_len_w;
   logic             bc_drop_w, mc_drop_w, bc_dcare_w, mc_dcare_w;

   rxf_cfg_regs #(
      .REG_W(REG_W), .LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES), .SEL_W(SEL_W),
      .MAXLEN_RST(MAXLEN_RST), .DROP_RST(DROP_RST), .DCARE_RST(DCARE_RST),
      .BCAST_BIT(BCAST_BIT), .MCAST_BIT(MCAST_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
      .station_o(station_w), .max_len_o(max_len_w),
      .bc_drop_o(bc_drop_w), .mc_drop_o(mc_drop_w),
      .bc_dcare_o(bc_dcare_w), .mc_dcare_o(mc_dcare_w)
   );

   logic            evt_w, runt_w;
   rxf_addr_flags_t flags_w;
   logic [LEN_W-1:0] len_w;

   rxf_addr_scan #(
      .ADDR_BYTES(ADDR_BYTES), .DATA_W(DATA_W), .LEN_W(LEN_W),
      .PARALLEL_CMP(PARALLEL_CMP)
   ) u_scan (
      .clk(clk), .rst_n(rst_n),
      .byte_vld(rx_byte_vld), .byte_data(rx_byte),
      .byte_sof(rx_sof), .byte_eof(rx_eof), .frame_len(rx_frame_len),
      .station(station_w),
      .evt_o(evt_w), .runt_o(runt_w), .flags_o(flags_w), .len_o(len_w)
   );

   rxf_decide #(
      .LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES)
   ) u_decide (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_w), .runt(runt_w), .flags(flags_w), .len(len_w),
      .max_len(max_len_w),
      .bc_drop(bc_drop_w), .mc_drop(mc_drop_w),
      .bc_dcare(bc_dcare_w), .mc_dcare(mc_dcare_w),
      .dec_vld_o(dec_vld), .dec_accept_o(dec_accept), .dec_class_o(dec_class)
   );

endmodule

// File: rtl/rx_accept_filter_chk.sv
module rx_accept_filter_chk
   import rxf_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int SEL_W = 3,
   parameter int ADDR_BYTES = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input logic [SEL_W-1:0] cfg_wr_sel,
   input logic             rx_byte_vld,
   input logic             rx_sof,
   input logic [LEN_W-1:0] rx_frame_len,
   input logic             dec_vld,
   input logic             dec_accept,
   input logic [1:0]       dec_class,
   input logic [LEN_W-1:0] max_len,
   input logic             bc_dcare,
   input logic             mc_dcare
);

   logic [LEN_W-1:0] len_seen_q, max_prev_q;
   logic             bc_dc_prev_q, mc_dc_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_seen_q   <= '0;
         max_prev_q   <= '0;
         bc_dc_prev_q <= 1'b0;
         mc_dc_prev_q <= 1'b0;
      end else begin
         if (rx_byte_vld && rx_sof) len_seen_q <= rx_frame_len;
         max_prev_q   <= max_len;
         bc_dc_prev_q <= bc_dcare;
         mc_dc_prev_q <= mc_dcare;
      end
   end

   wire len_fits = (len_seen_q <= max_prev_q) && (len_seen_q >= LEN_W'(ADDR_BYTES));

   assert_verdict_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(rx_byte_vld));

   assert_runt_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_class == CLS_RUNT) |-> !dec_accept);

   assert_len_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_accept) |-> (len_seen_q <= max_prev_q));

   assert_bcast_dcare_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_class == CLS_BROADCAST && bc_dc_prev_q && len_fits) |-> dec_accept);

   assert_mcast_dcare_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_class == CLS_MULTICAST && mc_dc_prev_q && len_fits) |-> dec_accept);

   assert_maxlen_only_own_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr_en && cfg_wr_sel == SEL_W'(SEL_MAXLEN)) |=> $stable(max_len));

   assert_accept_needs_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> dec_vld);

endmodule

bind rx_accept_filter rx_accept_filter_chk #(
   .LEN_W(LEN_W), .SEL_W(SEL_W), .ADDR_BYTES(ADDR_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
   .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof), .rx_frame_len(rx_frame_len),
   .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_class(dec_class),
   .max_len(max_len_w), .bc_dcare(bc_dcare_w), .mc_dcare(mc_dcare_w)
);

// File: tb/rx_accept_filter_tb.sv
`timescale 1ns/1ps
module rx_accept_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [2:0]  cfg_wr_sel;
   logic [31:0] cfg_wr_data;
   logic        rx_byte_vld;
   logic [7:0]  rx_byte;
   logic        rx_sof, rx_eof;
   logic [15:0] rx_frame_len;
   logic        dec_vld, dec_accept;
   logic [1:0]  dec_class;

   always #4 clk = ~clk;

   rx_accept_filter u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
      .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_frame_len(rx_frame_len),
      .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_class(dec_class)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [31:0] sh_a = 32'h0, sh_b = 32'h0, sh_max = 32'h600, sh_drop = 32'h0, sh_dc = 32'h3FFFF;

   localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] MCAST = 48'h0100_5E00_0001;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      case (sel)
         3'd0: sh_a = data;
         3'd1: sh_b = data;
         3'd2: sh_max = data;
         3'd3: sh_drop = data;
         3'd4: sh_dc = data;
         default: ;
      endcase
   endtask

   function automatic void expect_of(input logic [47:0] da, input int len, input int nbytes,
                                     output bit acc, output logic [1:0] cls);
      bit bc, mc, aok, lok;
      bc = (da == BCAST);
      mc = !bc && da[40];
      if (nbytes < 6) begin
         acc = 0; cls = 2'b11; return;
      end
      cls = bc ? 2'b10 : (mc ? 2'b01 : 2'b00);
      if (bc)      aok = sh_dc[9] || !sh_drop[9];
      else if (mc) aok = sh_dc[8] || !sh_drop[8];
      else         aok = (da == {sh_a, sh_b[31:16]});
      lok = (len <= int'(sh_max[15:0])) && (len >= 6);
      acc = aok && lok;
   endfunction

   // sends one frame; checks pulse count, pulse position, verdict and class
   task automatic run_frame(input string req, input logic [47:0] da, input int len, input int nbytes);
      int pulses = 0;
      int pos = -1;
      bit got_acc = 0;
      logic [1:0] got_cls = 2'b00;
      bit e_acc;
      logic [1:0] e_cls;
      int e_pos;
      expect_of(da, len, nbytes, e_acc, e_cls);
      e_pos = (nbytes < 6 ? nbytes : 6) - 1;
      for (int j = 0; j <= nbytes + 1; j++) begin
         @(negedge clk);
         if (dec_vld) begin
            pulses++; pos = j - 1; got_acc = dec_accept; got_cls = dec_class;
         end
         if (j < nbytes) begin
            rx_byte_vld  = 1'b1;
            rx_byte      = (j < 6) ? da[47 - 8*j -: 8] : 8'(j);
            rx_sof       = (j == 0);
            rx_eof       = (j == nbytes - 1);
            rx_frame_len = 16'(len);
         end else begin
            rx_byte_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
         end
      end
      check(pulses == 1, "R8", {req, " pulse count"}, 32'(pulses), 32'd1);
      check(pos == e_pos, "R8", {req, " pulse position"}, 32'(pos), 32'(e_pos));
      check(got_acc == e_acc, req, "accept", 32'(got_acc), 32'(e_acc));
      check(got_cls == e_cls, "R9", {req, " class"}, 32'(got_cls), 32'(e_cls));
   endtask

   task automatic t_reset;
      check(dec_vld == 1'b0, "R1", "dec_vld after reset", 32'(dec_vld), 32'd0);
      check(dec_accept == 1'b0, "R1", "dec_accept after reset", 32'(dec_accept), 32'd0);
      run_frame("R1", BCAST, 64, 8);
      run_frame("R1", MCAST, 64, 8);
      run_frame("R1", BCAST, 1536, 8);
   endtask

   task automatic t_length;
      run_frame("R2", BCAST, 1537, 8);
      cfg_write(3'd2, 32'hABCD_0040);
      run_frame("R2", BCAST, 64, 8);
      run_frame("R2", MCAST, 65, 8);
      cfg_write(3'd2, 32'h0000_0600);
   endtask

   task automatic t_runt;
      run_frame("R3", BCAST, 3, 3);
      run_frame("R3", BCAST, 1, 1);
      run_frame("R3", BCAST, 5, 8);
   endtask

   task automatic t_classes;
      cfg_write(3'd4, 32'h0);
      run_frame("R4", BCAST, 80, 8);
      cfg_write(3'd3, 32'h200);
      run_frame("R4", BCAST, 80, 8);
      run_frame("R5", MCAST, 80, 8);
      cfg_write(3'd3, 32'h300);
      run_frame("R5", MCAST, 80, 8);
      run_frame("R5", 48'h3300_0000_0001, 80, 8);
      cfg_write(3'd4, 32'h200);
      run_frame("R6", BCAST, 80, 8);
      run_frame("R6", MCAST, 80, 8);
      cfg_write(3'd4, 32'h100);
      run_frame("R6", MCAST, 80, 8);
      run_frame("R6", BCAST, 80, 8);
   endtask

   task automatic t_unicast;
      cfg_write(3'd0, 32'h0211_2233);
      cfg_write(3'd1, 32'h4455_ABCD);
      run_frame("R7", 48'h0211_2233_4455, 100, 10);
      run_frame("R7", 48'h0211_2233_4456, 100, 10);
      run_frame("R7", 48'h0611_2233_4455, 100, 10);
      run_frame("R7", 48'h4455_0211_2233, 100, 10);
      cfg_write(3'd1, 32'h4455_0000);
      run_frame("R7", 48'h0211_2233_4455, 100, 10);
   endtask

   task automatic t_bad_sel;
      cfg_write(3'd5, 32'h0);
      cfg_write(3'd6, 32'h0);
      cfg_write(3'd7, 32'h0);
      run_frame("R10", 48'h0211_2233_4455, 64, 8);
      run_frame("R10", MCAST, 64, 8);
      run_frame("R10", BCAST, 1536, 8);
   endtask

   task automatic t_restart;
      int stray = 0;
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         if (dec_vld) stray++;
         rx_byte_vld = 1'b1; rx_byte = 8'hFF; rx_sof = (j == 0); rx_eof = 1'b0;
         rx_frame_len = 16'd64;
      end
      run_frame("R8", 48'h0211_2233_4455, 64, 14);
      check(stray == 0, "R8", "no verdict for abandoned frame", 32'(stray), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL R8 watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cfg_wr_en = 1'b0; cfg_wr_sel = 3'd0; cfg_wr_data = 32'h0;
      rx_byte_vld = 1'b0; rx_byte = 8'h0; rx_sof = 1'b0; rx_eof = 1'b0; rx_frame_len = 16'h0;
      repeat (3) @(negedge clk);
      check(dec_vld == 1'b0, "R1", "dec_vld in reset", 32'(dec_vld), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_length();
      t_runt();
      t_classes();
      t_unicast();
      t_bad_sel();
      t_restart();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule